// File: doc/BRIEF.md
# Receive Character Buffer with Watermark and Idle Aging

This block is a 32-deep receive queue placed between a serial receiver core and the register read port of a UART. Each slot holds one received byte together with four per-character error flags: framing, parity, overrun and line break. The receiver core pushes characters with a one-cycle valid pulse. The read side pops them through a valid/ready handshake.

Two level indications follow the fill count: a watermark bit that is high while the count is at or above a programmable threshold, and a data-available bit that is high while anything is stored. Two sticky events are kept as well. One is an aging event, raised when stored data has seen no arrival and no read for eight character periods, with the period supplied as a strobe. The other is a break event, raised when a character marked as a line break arrives. The sticky bits are cleared by writing ones. A single interrupt line combines the three interrupt sources with their enables.

Back-pressure rules: the receive side has no ready signal, because a serial line cannot be stalled. A character that arrives while the queue is full is dropped, and the loss is recorded on the newest stored entry. The read side moves a word on every cycle in which `out_valid` and `out_ready` are both high. `out_word` is stable while `out_valid` is high and `out_ready` is low.

Top module: `rx_age_fifo`

## Requirements
- R1: Words leave in arrival order. `out_word` carries the data byte in bits 7:0, the framing flag in bit 8, the parity flag in bit 9, the overrun flag in bit 10 and the break flag in bit 11.
- R2: The queue holds up to 32 words. `out_valid` is high exactly when the queue holds at least one word, and a pop happens on a cycle with `out_valid` and `out_ready` both high.
- R3: A push into a full queue with no pop in the same cycle is dropped, and bit 10 of the newest stored word becomes 1. A push that coincides with a pop from a full queue is stored.
- R4: `status[0]` (watermark) is 1 exactly when the stored count is greater than or equal to `thresh`. It follows the count, with no latching.
- R5: `status[3]` (data available) is 1 exactly when the stored count is at least one, independent of `thresh`.
- R6: `status[1]` (aging) becomes 1 after the clock edge of the eighth `char_tick` that is counted while the queue is non-empty with no push or pop since the last push or pop. Any push or pop restarts the count, and the count stays at zero while the queue is empty. Once the count has reached eight, further ticks do not raise the event again until a new push or pop.
- R7: `status[2]` (break) becomes 1 after any cycle in which `in_valid` and `in_break` are both high, whether or not the character was stored.
- R8: A cycle with `clr_valid` high clears each of `status[1]` and `status[2]` whose bit is 1 in `clr_mask`. A new event in that same cycle wins over the clear. Ones in `clr_mask` bits 0 and 3 have no effect.
- R9: `irq` is the OR over bits 0 to 2 of `status[k] & irq_en[k]`. Break therefore interrupts whenever `irq_en[2]` is set, whatever the other enables are.
- R10: After reset the queue is empty, `status[2:1]` are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Character arrives this cycle |
| in_data | input | 8 | Received byte |
| in_frame_err | input | 1 | Framing error for this character |
| in_parity_err | input | 1 | Parity error for this character |
| in_overrun_err | input | 1 | Overrun reported by the receiver core |
| in_break | input | 1 | Character is a line break |
| out_valid | output | 1 | Head word available |
| out_ready | input | 1 | Reader takes the head word |
| out_word | output | 12 | Head word: flags and byte |
| char_tick | input | 1 | One-cycle strobe per character period |
| thresh | input | 6 | Watermark threshold |
| irq_en | input | 3 | Interrupt enables for watermark, aging and break |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 4 | Bits to clear, aligned with status |
| status | output | 4 | {available, break, aging, watermark} |
| irq | output | 1 | Combined interrupt |

## Verification
Two pairs of functions can fall in the same cycle. The first is a push and a pop while the queue is full: the bench fills all 32 slots, raises `in_valid` and `out_ready` in one cycle, and expects the new word to be stored and the head to leave. It then checks the full drain order against its own model. The second is the eighth aging tick and a write-one clear of the aging bit: the bench lines them up on one edge and expects the bit to read 1 afterwards, because the new event wins over the clear.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ovr;
    logic              par;
    logic              frm;
    logic [BYTE_W-1:0] data;
  } rxf_entry_t;

  localparam int ENTRY_W  = $bits(rxf_entry_t);
  localparam int ST_HIWAT = 0;
  localparam int ST_AGE   = 1;
  localparam int ST_BRK   = 2;
  localparam int ST_AVAIL = 3;
  localparam int ST_W     = 4;
  localparam int IRQ_W    = 3;
  localparam int STICKY_N = 2;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  rxf_entry_t       push_entry,
  input  logic             pop_req,
  output rxf_entry_t       head,
  output logic [CNT_W-1:0] count,
  output logic             popped
);
  rxf_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, last_ptr;
  logic             full, empty, do_push, do_pop, drop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign do_pop   = pop_req && !empty;
  assign do_push  = push_valid && (!full || do_pop);
  assign drop     = push_valid && full && !do_pop;
  assign last_ptr = (wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - 1'b1;
  assign head     = mem[rd_ptr];
  assign popped   = do_pop;

  always_ff @(posedge clk) begin
    if (do_push)   mem[wr_ptr]         <= push_entry;
    else if (drop) mem[last_ptr].ovr   <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      unique case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full && !pop_req) |=> (count == CNT_W'(DEPTH)));
  assert_full_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop_req && full) |=> (count == CNT_W'(DEPTH)));
  assert_pop_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push_valid) |=> (count == '0));
endmodule

// File: rtl/rxf_age_timer.sv
module rxf_age_timer #(
  parameter  int AGE_TICKS = 8,
  localparam int AC_W      = $clog2(AGE_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic activity,
  input  logic empty,
  output logic fire
);
  logic [AC_W-1:0] age_cnt;

  assign fire = tick && !activity && !empty && (age_cnt == AC_W'(AGE_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      age_cnt <= '0;
    else if (activity || empty)                      age_cnt <= '0;
    else if (tick && age_cnt != AC_W'(AGE_TICKS))    age_cnt <= age_cnt + 1'b1;
  end

  assert_age_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> (age_cnt == '0));
  assert_age_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (age_cnt == AC_W'(AGE_TICKS)));
endmodule

// File: rtl/rxf_status.sv
module rxf_status
  import rxf_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] thresh,
  input  logic             age_fire,
  input  logic             brk_evt,
  input  logic             clr_valid,
  input  logic [ST_W-1:0]  clr_mask,
  input  logic [IRQ_W-1:0] irq_en,
  output logic [ST_W-1:0]  status,
  output logic             irq
);
  localparam int STICKY_BASE = ST_AGE;

  logic [STICKY_N-1:0] sticky, set_vec;

  assign set_vec = {brk_evt, age_fire};

  for (genvar k = 0; k < STICKY_N; k++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sticky[k] <= 1'b0;
      else if (set_vec[k])
        sticky[k] <= 1'b1;
      else if (clr_valid && clr_mask[STICKY_BASE + k])
        sticky[k] <= 1'b0;
    end
  end

  assign status[ST_HIWAT] = (count >= thresh);
  assign status[ST_AGE]   = sticky[0];
  assign status[ST_BRK]   = sticky[1];
  assign status[ST_AVAIL] = (count != '0);
  assign irq              = |(status[IRQ_W-1:0] & irq_en);

  assert_age_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    age_fire |=> status[ST_AGE]);
  assert_brk_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> status[ST_BRK]);
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && clr_mask[ST_AGE] && !age_fire) |=> !status[ST_AGE]);
  assert_brk_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_BRK] && irq_en[ST_BRK]) |-> irq);
endmodule

// File: rtl/rx_age_fifo.sv
module rx_age_fifo
  import rxf_pkg::*;
#(
  parameter  int DEPTH     = 32,
  parameter  int AGE_TICKS = 8,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [BYTE_W-1:0]  in_data,
  input  logic               in_frame_err,
  input  logic               in_parity_err,
  input  logic               in_overrun_err,
  input  logic               in_break,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ENTRY_W-1:0] out_word,
  input  logic               char_tick,
  input  logic [CNT_W-1:0]   thresh,
  input  logic [IRQ_W-1:0]   irq_en,
  input  logic               clr_valid,
  input  logic [ST_W-1:0]    clr_mask,
  output logic [ST_W-1:0]    status,
  output logic               irq
);
  rxf_entry_t       in_entry, head;
  logic [CNT_W-1:0] count;
  logic             popped, age_fire, empty;

  assign in_entry = '{brk: in_break, ovr: in_overrun_err, par: in_parity_err,
                      frm: in_frame_err, data: in_data};
  assign empty     = (count == '0);
  assign out_valid = !empty;
  assign out_word  = head;

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (in_valid),
    .push_entry (in_entry),
    .pop_req    (out_ready),
    .head       (head),
    .count      (count),
    .popped     (popped)
  );

  rxf_age_timer #(.AGE_TICKS(AGE_TICKS)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (char_tick),
    .activity (in_valid || popped),
    .empty    (empty),
    .fire     (age_fire)
  );

  rxf_status #(.CNT_W(CNT_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .thresh    (thresh),
    .age_fire  (age_fire),
    .brk_evt   (in_valid && in_break),
    .clr_valid (clr_valid),
    .clr_mask  (clr_mask),
    .irq_en    (irq_en),
    .status    (status),
    .irq       (irq)
  );

  assert_head_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !(in_valid && count == CNT_W'(1)))
      |=> (out_valid && $stable(out_word) || !$past(out_valid)));
  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (status[2:1] == 2'b00));
endmodule

// File: tb/tb_rx_age_fifo.sv
`timescale 1ns/100ps
module tb_rx_age_fifo;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_frame_err = 0, in_parity_err = 0, in_overrun_err = 0, in_break = 0;
  logic [7:0]  in_data = 0;
  logic        out_valid, out_ready = 0;
  logic [11:0] out_word;
  logic        char_tick = 0, clr_valid = 0, irq;
  logic [5:0]  thresh = 6'd24;
  logic [2:0]  irq_en = 0;
  logic [3:0]  clr_mask = 0, status;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [11:0] q[$];

  always #2.5 clk = ~clk;

  rx_age_fifo dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic push(input logic [11:0] w);
    logic [11:0] t;
    in_valid = 1;
    {in_break, in_overrun_err, in_parity_err, in_frame_err, in_data} = w;
    step();
    in_valid = 0; in_break = 0;
    if (q.size() < 32) q.push_back(w);
    else begin t = q[q.size()-1]; t[10] = 1'b1; q[q.size()-1] = t; end
  endtask

  task automatic pop_chk(input string req);
    chk({req, " valid"}, out_valid, 1);
    chk({req, " word"}, out_word, q[0]);
    out_ready = 1; step(); out_ready = 0;
    q.delete(0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin char_tick = 1; step(); char_tick = 0; end
  endtask

  task automatic clear(input logic [3:0] m);
    clr_valid = 1; clr_mask = m; step(); clr_valid = 0; clr_mask = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [11:0] w;
    step(); step(); rst_n = 1; step();
    // R10 reset state
    chk("R10 status", status[2:1], 0);
    chk("R10 irq", irq, 0);
    chk("R10 empty", out_valid, 0);

    // R4 / R5 sweep of every fill level against every threshold
    for (int lvl = 0; lvl <= 32; lvl++) begin
      for (int thr = 0; thr <= 33; thr++) begin
        thresh = 6'(thr); #0.1;
        chk("R4 watermark", status[0], (lvl >= thr) ? 1 : 0);
      end
      chk("R5 available", status[3], (lvl > 0) ? 1 : 0);
      chk("R2 out_valid", out_valid, (lvl > 0) ? 1 : 0);
      if (lvl < 32) begin
        w[7:0] = 8'(lvl * 37 + 11);
        w[8] = lvl[0]; w[9] = lvl[1]; w[10] = lvl[2]; w[11] = (lvl == 5);
        push(w);
      end
    end
    thresh = 6'd32;
    // R3 overflow drops and marks newest entry
    push(12'h0AA); push(12'h0BB);
    chk("R3 still full", status[0], 1);
    // R3 simultaneous push and pop while full
    chk("R3 head before swap", out_word, q[0]);
    in_valid = 1; in_data = 8'hCC; out_ready = 1; step();
    in_valid = 0; out_ready = 0;
    q.delete(0); q.push_back(12'h0CC);
    chk("R3 full after swap", status[0], 1);
    // R1 drain order and layout
    for (int i = 0; i < 32; i++) pop_chk("R1 drain");
    chk("R2 empty after drain", out_valid, 0);
    chk("R5 cleared", status[3], 0);

    // R7 break seen during fill, R8 clear
    chk("R7 break set", status[2], 1);
    chk("R6 no ticks no aging", status[1], 0);
    clear(4'hF);
    chk("R8 cleared all", status[2:1], 0);
    thresh = 6'd1;
    push(12'h05A);
    clear(4'hF);
    chk("R8 level bit0 unaffected", status[0], 1);
    chk("R8 level bit3 unaffected", status[3], 1);

    // R6 aging
    ticks(7); chk("R6 seven ticks", status[1], 0);
    ticks(1); chk("R6 eighth tick", status[1], 1);
    ticks(10); clear(4'h2); chk("R8 aging cleared", status[1], 0);
    ticks(10); chk("R6 no refire", status[1], 0);
    push(12'h066); ticks(5); pop_chk("R6 pop");
    ticks(7); chk("R6 pop restarts", status[1], 0);
    ticks(1); chk("R6 after pop restart", status[1], 1);
    clear(4'h2); chk("R8 clear again", status[1], 0);
    push(12'h077); ticks(7);
    char_tick = 1; clr_valid = 1; clr_mask = 4'h2; step();
    char_tick = 0; clr_valid = 0; clr_mask = 0;
    chk("R8 set wins over clear", status[1], 1);
    pop_chk("R1 drain a"); pop_chk("R1 drain b");
    clear(4'hF); ticks(12);
    chk("R6 empty no aging", status, 0);

    // R9 interrupt combining
    for (int en = 0; en < 8; en++) begin
      irq_en = 3'(en); #0.1; chk("R9 idle", irq, 0);
    end
    push(12'h833);
    for (int en = 0; en < 8; en++) begin
      irq_en = 3'(en); #0.1; chk("R9 wm+break", irq, ((en & 5) != 0) ? 1 : 0);
    end
    ticks(8);
    chk("R6 aging for irq", status[1], 1);
    for (int en = 0; en < 8; en++) begin
      irq_en = 3'(en); #0.1; chk("R9 all", irq, (en != 0) ? 1 : 0);
    end
    pop_chk("R1 last");

    done = 1;
    summary();
    $finish;
  end
endmodule